// File: doc/BRIEF.md
# Effective-Address Byte Parser

This block walks through the addressing bytes of one instruction operand, one byte per clock, over a valid/ready byte stream. The first byte it accepts is the mod/reg/rm byte. From that byte and the address-size mode it decides whether a scale-index-base byte comes next and how many displacement bytes follow. It then collects the displacement least-significant byte first and widens it to 32 bits.

After the last byte of the operand it raises a one-cycle completion strobe. While the strobe is high the outputs show the decoded fields, flags for base register, index register and register-direct operand, the sign-extended displacement and the number of bytes consumed. On the next cycle the parser is ready for the next operand's first byte. An upstream instruction decoder uses it after prefix and opcode handling. The address arithmetic itself happens downstream.

Top module: `ea_byte_parser`

## Requirements
- R1: The first accepted byte is split as mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0, and these appear on `mod_o`, `reg_o` and `rm_o`. The reg value never changes the number of bytes consumed or any flag.
- R2: mod = 3 gives a register-direct operand: `reg_direct` = 1, `base_present` = `index_present` = `sib_present` = 0, displacement 0 and length 1, in both modes.
- R3: In 16-bit mode (`mode32` = 0) no SIB byte is read. mod 0/1/2 mean 0/1/2 displacement bytes. `base_present` is 1 for rm in {0,1,2,3,6,7} and `index_present` is 1 for rm in {0..5}.
- R4: In 16-bit mode, mod = 0 with rm = 6 reads a 2-byte displacement and reports no base and no index.
- R5: In 32-bit mode (`mode32` = 1), for rm ≠ 4, mod 0/1/2 mean 0/1/4 displacement bytes, `base_present` = 1 and `index_present` = 0.
- R6: In 32-bit mode, rm = 4 with mod ≠ 3 reads one SIB byte next. `scale_o` = bits 7:6, `index_o` = bits 5:3, `base_o` = bits 2:0, and `sib_present` = 1. When no SIB byte is read these three fields report 0.
- R7: In 32-bit mode, mod = 0 with rm = 5 reads a 4-byte displacement and reports no base and no index.
- R8: With a SIB byte, mod = 0 and SIB base = 5 give no base register and a 4-byte displacement. The index is still decoded.
- R9: A SIB index value of 4 gives `index_present` = 0. Any other value gives 1.
- R10: Displacement bytes are assembled least-significant first. 1- and 2-byte displacements are sign-extended to 32 bits, and no displacement reports 0.
- R11: `in_ready` is 1 in every cycle except the completion cycle. A byte is consumed only on a clock where both `in_valid` and `in_ready` are 1, and the parser waits indefinitely while `in_valid` is 0.
- R12: `done` rises in the cycle after the last byte is consumed, lasts exactly one cycle and is followed by `in_ready` = 1. `len_o` = 1 + SIB byte + displacement bytes (1 to 6).
- R13: A synchronous active-low reset returns the parser to waiting for a first byte (`in_ready` = 1, `done` = 0), even mid-operand. `mode32` is sampled only with the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit; sampled with first byte |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Addressing byte |
| in_ready | output | 1 | Parser can take a byte this cycle |
| done | output | 1 | One-cycle completion strobe; fields below valid |
| mod_o | output | 2 | mod field |
| reg_o | output | 3 | reg/opcode-extension field |
| rm_o | output | 3 | rm field |
| scale_o | output | 2 | SIB scale (0 if no SIB) |
| index_o | output | 3 | SIB index (0 if no SIB) |
| base_o | output | 3 | SIB base (0 if no SIB) |
| sib_present | output | 1 | A SIB byte was read |
| base_present | output | 1 | A base register takes part |
| index_present | output | 1 | An index register takes part |
| reg_direct | output | 1 | Operand is a register, not memory |
| disp_o | output | 32 | Sign-extended displacement |
| len_o | output | 3 | Bytes consumed for this operand |

## Verification
A wrong internal state in this block shows up as a byte count that is too short or too long. With a short count, `done` rises early and the following displacement byte is taken as the next operand's first byte. With a long count, `done` is late and the next first byte is taken into the displacement. Either way the strobe timing differs from the model within one cycle of the faulty decision, and every operand after it is misframed. A bad byte-lane or sign-extension choice shows only in `disp_o` during the strobe. So the displacement is compared on every completion, with values that have the top bit set and values that have it clear.

// File: rtl/ea_pkg.sv
// Package: shared state type and field codes for the effective-address parser.
// Assumes 8-bit addressing bytes; the code values below are fixed by the encoding.
package ea_pkg;
    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_SIB   = 2'd1,
        ST_DISP  = 2'd2,
        ST_DONE  = 2'd3
    } ea_state_e;

    localparam logic [1:0] MOD_REGISTER  = 2'd3;
    localparam logic [2:0] RM16_DISPONLY = 3'd6;
    localparam logic [2:0] RM32_SIB      = 3'd4;
    localparam logic [2:0] RM32_DISPONLY = 3'd5;
    localparam logic [2:0] SIB_NO_INDEX  = 3'd4;
    localparam logic [2:0] SIB_NO_BASE   = 3'd5;
endpackage

// File: rtl/ea_modrm_decode.sv
// ea_modrm_decode: combinational decode of the mod and rm fields under the
// selected address size. Gives SIB need, displacement byte count and the
// register flags that hold when no SIB byte is read.
// Assumes: with a SIB byte, the mod=0 byte count is settled later by ea_sib_decode.
module ea_modrm_decode
    import ea_pkg::*;
(
    input  logic [1:0] mod_f,
    input  logic [2:0] rm_f,
    input  logic       mode32,
    output logic       need_sib,
    output logic [2:0] disp_bytes,
    output logic       base_p,
    output logic       index_p,
    output logic       direct
);
    // Case split on register form, 16-bit table and 32-bit table.
    always_comb begin
        need_sib   = 1'b0;
        disp_bytes = 3'd0;
        base_p     = 1'b0;
        index_p    = 1'b0;
        direct     = 1'b0;
        if (mod_f == MOD_REGISTER) begin
            direct = 1'b1;
        end else if (!mode32) begin
            if (mod_f == 2'd0 && rm_f == RM16_DISPONLY) begin
                disp_bytes = 3'd2;
            end else begin
                disp_bytes = {1'b0, mod_f};
                base_p     = (rm_f != 3'd4) && (rm_f != 3'd5);
                index_p    = (rm_f[2:1] != 2'b11);
            end
        end else if (rm_f == RM32_SIB) begin
            need_sib   = 1'b1;
            disp_bytes = (mod_f == 2'd1) ? 3'd1 : (mod_f == 2'd2) ? 3'd4 : 3'd0;
        end else begin
            if (mod_f == 2'd0) begin
                disp_bytes = (rm_f == RM32_DISPONLY) ? 3'd4 : 3'd0;
                base_p     = (rm_f != RM32_DISPONLY);
            end else begin
                disp_bytes = (mod_f == 2'd1) ? 3'd1 : 3'd4;
                base_p     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ea_sib_decode.sv
// ea_sib_decode: combinational decode of the scale-index-base byte together
// with the mod value from the first byte. Gives register flags and final
// displacement byte count. Assumes it is only consulted in 32-bit mode.
module ea_sib_decode
    import ea_pkg::*;
(
    input  logic [1:0] mod_f,
    input  logic [2:0] index_f,
    input  logic [2:0] base_f,
    output logic [2:0] disp_bytes,
    output logic       base_p,
    output logic       index_p
);
    logic no_base;

    // Flags and displacement length from the SIB fields.
    always_comb begin
        no_base    = (mod_f == 2'd0) && (base_f == SIB_NO_BASE);
        base_p     = !no_base;
        index_p    = (index_f != SIB_NO_INDEX);
        if (mod_f == 2'd0)
            disp_bytes = no_base ? 3'd4 : 3'd0;
        else if (mod_f == 2'd1)
            disp_bytes = 3'd1;
        else
            disp_bytes = 3'd4;
    end
endmodule

// File: rtl/ea_disp_gather.sv
// ea_disp_gather: collects displacement bytes lowest lane first and presents
// them widened to DISP_W bits, sign-extending 1- and 2-byte values.
// Assumes clear precedes each operand and at most DISP_W/8 loads follow.
module ea_disp_gather #(
    parameter int DISP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [7:0]        byte_in,
    input  logic [2:0]        nbytes,
    output logic [DISP_W-1:0] disp_out
);
    localparam int NB    = DISP_W / 8;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [DISP_W-1:0] raw;
    logic [IDX_W-1:0]  lane;

    // Lane pointer: reset on clear, step on each load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            lane <= '0;
        else if (load)
            lane <= lane + 1'b1;
    end

    // One register per byte lane, written when the pointer selects it.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                raw[g*8 +: 8] <= 8'd0;
            else if (load && lane == IDX_W'(g))
                raw[g*8 +: 8] <= byte_in;
        end
    end

    // Widen by the number of bytes gathered.
    always_comb begin
        case (nbytes)
            3'd1:    disp_out = {{(DISP_W-8){raw[7]}}, raw[7:0]};
            3'd2:    disp_out = {{(DISP_W-16){raw[15]}}, raw[15:0]};
            3'(NB):  disp_out = raw;
            default: disp_out = '0;
        endcase
    end
endmodule

// File: rtl/ea_byte_parser.sv
// ea_byte_parser: streams an operand's addressing bytes (mod/reg/rm, optional
// SIB, displacement) over valid/ready and reports the decoded operand with a
// one-cycle done strobe. Assumes mode32 is valid with the first byte; it is
// ignored for later bytes. Fields hold their values until the next first byte.
module ea_byte_parser
    import ea_pkg::*;
#(
    parameter int DISP_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              done,
    output logic [1:0]        mod_o,
    output logic [2:0]        reg_o,
    output logic [2:0]        rm_o,
    output logic [1:0]        scale_o,
    output logic [2:0]        index_o,
    output logic [2:0]        base_o,
    output logic              sib_present,
    output logic              base_present,
    output logic              index_present,
    output logic              reg_direct,
    output logic [DISP_W-1:0] disp_o,
    output logic [LEN_W-1:0]  len_o
);
    ea_state_e        state;
    logic             accept;
    logic [2:0]       dlen_r;
    logic [2:0]       left_r;

    logic             fd_sib, fd_base, fd_index, fd_direct;
    logic [2:0]       fd_disp;
    logic             sd_base, sd_index;
    logic [2:0]       sd_disp;

    assign in_ready = (state != ST_DONE);
    assign done     = (state == ST_DONE);
    assign accept   = in_valid && in_ready;

    ea_modrm_decode u_modrm (
        .mod_f      (in_byte[7:6]),
        .rm_f       (in_byte[2:0]),
        .mode32     (mode32),
        .need_sib   (fd_sib),
        .disp_bytes (fd_disp),
        .base_p     (fd_base),
        .index_p    (fd_index),
        .direct     (fd_direct)
    );

    ea_sib_decode u_sib (
        .mod_f      (mod_o),
        .index_f    (in_byte[5:3]),
        .base_f     (in_byte[2:0]),
        .disp_bytes (sd_disp),
        .base_p     (sd_base),
        .index_p    (sd_index)
    );

    ea_disp_gather #(.DISP_W(DISP_W)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept && state == ST_FIRST),
        .load     (accept && state == ST_DISP),
        .byte_in  (in_byte),
        .nbytes   (dlen_r),
        .disp_out (disp_o)
    );

    // Parser sequencer: latch fields and count bytes as they are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_FIRST;
            mod_o         <= '0;
            reg_o         <= '0;
            rm_o          <= '0;
            scale_o       <= '0;
            index_o       <= '0;
            base_o        <= '0;
            sib_present   <= 1'b0;
            base_present  <= 1'b0;
            index_present <= 1'b0;
            reg_direct    <= 1'b0;
            dlen_r        <= '0;
            left_r        <= '0;
            len_o         <= '0;
        end else begin
            case (state)
                ST_FIRST: if (accept) begin
                    mod_o         <= in_byte[7:6];
                    reg_o         <= in_byte[5:3];
                    rm_o          <= in_byte[2:0];
                    scale_o       <= '0;
                    index_o       <= '0;
                    base_o        <= '0;
                    sib_present   <= fd_sib;
                    base_present  <= fd_base;
                    index_present <= fd_index;
                    reg_direct    <= fd_direct;
                    dlen_r        <= fd_disp;
                    left_r        <= fd_disp;
                    len_o         <= LEN_W'(1);
                    if (fd_sib)
                        state <= ST_SIB;
                    else if (fd_disp != 3'd0)
                        state <= ST_DISP;
                    else
                        state <= ST_DONE;
                end
                ST_SIB: if (accept) begin
                    scale_o       <= in_byte[7:6];
                    index_o       <= in_byte[5:3];
                    base_o        <= in_byte[2:0];
                    base_present  <= sd_base;
                    index_present <= sd_index;
                    dlen_r        <= sd_disp;
                    left_r        <= sd_disp;
                    len_o         <= len_o + LEN_W'(1);
                    state         <= (sd_disp != 3'd0) ? ST_DISP : ST_DONE;
                end
                ST_DISP: if (accept) begin
                    left_r <= left_r - 3'd1;
                    len_o  <= len_o + LEN_W'(1);
                    if (left_r == 3'd1)
                        state <= ST_DONE;
                end
                default: state <= ST_FIRST;
            endcase
        end
    end
endmodule

// File: rtl/ea_byte_parser_chk.sv
// ea_byte_parser_chk: temporal checks on the parser's ports, bound to every
// instance of ea_byte_parser. Assumes the default parameter widths.
module ea_byte_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       done,
    input logic [1:0] mod_o,
    input logic [2:0] rm_o,
    input logic [2:0] index_o,
    input logic       sib_present,
    input logic       base_present,
    input logic       index_present,
    input logic       reg_direct,
    input logic [2:0] len_o
);
    // R12
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);
    // R11
    ready_low_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);
    // R11
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !done);
    // R2
    direct_no_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reg_direct) |-> (!base_present && !index_present && !sib_present && len_o == 3'd1));
    // R12
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_o >= 3'd1 && len_o <= 3'd6));
    // R6
    sib_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sib_present) |-> (mod_o != 2'd3 && rm_o == 3'd4 && len_o >= 3'd2));
    // R9
    no_index_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sib_present && index_o == 3'd4) |-> !index_present);
endmodule

bind ea_byte_parser ea_byte_parser_chk u_chk (.*);

// File: tb/ea_byte_parser_test.sv
// Bench: behavioural reference model fed by the same stream, compared each cycle.
module ea_byte_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        in_ready, done;
    logic [1:0]  mod_o, scale_o;
    logic [2:0]  reg_o, rm_o, index_o, base_o, len_o;
    logic        sib_present, base_present, index_present, reg_direct;
    logic [31:0] disp_o;

    always #2.5 clk = ~clk;

    ea_byte_parser uut (.*);

    integer checks = 0;
    integer fails  = 0;
    integer cycles = 0;
    logic   running = 1'b0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Total byte count implied by the bytes known so far.
    function automatic int need_len(input logic [7:0] b0, input logic [7:0] b1, input bit have1, input bit m32);
        int md, rm, d;
        md = b0[7:6]; rm = b0[2:0];
        if (md == 3) return 1;
        if (!m32) begin
            d = (md == 0) ? ((rm == 6) ? 2 : 0) : md;
            return 1 + d;
        end
        if (rm == 4) begin
            if (!have1) return 2;
            d = (md == 0) ? ((b1[2:0] == 5) ? 4 : 0) : (md == 1) ? 1 : 4;
            return 2 + d;
        end
        d = (md == 0) ? ((rm == 5) ? 4 : 0) : (md == 1) ? 1 : 4;
        return 1 + d;
    endfunction

    // Reference model state
    logic [7:0] mb [0:5];
    int         mcnt = 0;
    bit         mmode = 0;
    bit         exp_done = 0;
    logic [1:0] e_mod, e_scale;
    logic [2:0] e_reg, e_rm, e_idx, e_base;
    bit         e_sib, e_bp, e_ip, e_dir;
    logic [31:0] e_disp;
    int         e_len;
    string      e_tag, e_itag;

    task automatic model_finish();
        int hdr, n;
        e_mod = mb[0][7:6]; e_reg = mb[0][5:3]; e_rm = mb[0][2:0];
        e_sib = mmode && e_mod != 2'd3 && e_rm == 3'd4;
        e_scale = e_sib ? mb[1][7:6] : 2'd0;
        e_idx   = e_sib ? mb[1][5:3] : 3'd0;
        e_base  = e_sib ? mb[1][2:0] : 3'd0;
        hdr = e_sib ? 2 : 1;
        n = mcnt - hdr;
        e_disp = 32'd0;
        for (int i = 0; i < n; i++) e_disp[i*8 +: 8] = mb[hdr+i];
        if (n == 1) e_disp = 32'($signed(e_disp[7:0]));
        if (n == 2) e_disp = 32'($signed(e_disp[15:0]));
        e_len = mcnt;
        e_dir = 0; e_bp = 0; e_ip = 0; e_itag = "R3";
        if (e_mod == 2'd3) begin
            e_dir = 1; e_tag = "R2"; e_itag = "R2";
        end else if (!mmode) begin
            if (e_mod == 0 && e_rm == 6) begin e_tag = "R4"; e_itag = "R4"; end
            else begin
                e_tag = "R3";
                e_bp = (e_rm != 4 && e_rm != 5);
                e_ip = (e_rm < 6);
            end
        end else if (!e_sib) begin
            e_tag = (e_mod == 0 && e_rm == 5) ? "R7" : "R5";
            e_itag = e_tag;
            e_bp = !(e_mod == 0 && e_rm == 5);
        end else begin
            e_bp = !(e_mod == 0 && e_base == 5);
            e_ip = (e_idx != 4);
            e_tag = e_bp ? "R6" : "R8";
            e_itag = e_ip ? "R6" : "R9";
        end
    endtask

    // Model advance on each clock edge (inputs are driven at the falling edge).
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; exp_done = 0;
        end else if (exp_done) begin
            exp_done = 0;
        end else if (in_valid) begin
            if (mcnt == 0) mmode = mode32;
            mb[mcnt] = in_byte;
            mcnt++;
            if (mcnt == need_len(mb[0], mb[1], mcnt > 1, mmode)) begin
                model_finish();
                exp_done = 1;
                mcnt = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (running && rst_n) begin
            check("R11", "in_ready", in_ready, !exp_done);
            check("R12", "done", done, exp_done);
            if (exp_done && done) begin
                check("R1", "mod", mod_o, e_mod);
                check("R1", "reg", reg_o, e_reg);
                check("R1", "rm", rm_o, e_rm);
                check("R6", "sib_present", sib_present, e_sib);
                check("R6", "scale", scale_o, e_scale);
                check("R6", "index", index_o, e_idx);
                check("R6", "base", base_o, e_base);
                check(e_tag, "base_present", base_present, e_bp);
                check(e_itag, "index_present", index_present, e_ip);
                check("R2", "reg_direct", reg_direct, e_dir);
                check("R10", "disp", disp_o, e_disp);
                check("R12", "len", len_o, e_len);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL R11 watchdog: actual %0d expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Offer one operand's bytes; gaps of idle cycles when gap is set.
    task automatic send(input bit m32, input logic [7:0] b [0:5], input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            forever begin
                @(negedge clk);
                if (gap && ($urandom % 3 == 0)) begin
                    in_valid = 1'b0;
                    in_byte  = 8'($urandom);
                    mode32   = 1'($urandom);
                end else begin
                    in_valid = 1'b1;
                    in_byte  = b[i];
                    mode32   = (i == 0) ? m32 : 1'($urandom);
                    if (in_ready) break;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Build an operand from a first byte (and SIB byte) with fixed displacement bytes.
    task automatic directed(input bit m32, input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] b [0:5];
        logic [7:0] pat [0:3];
        int n, k;
        pat[0] = 8'h81; pat[1] = 8'hFE; pat[2] = 8'h7F; pat[3] = 8'h12;
        b[0] = b0; b[1] = b1;
        n = need_len(b0, b1, 1, m32);
        k = (m32 && b0[7:6] != 2'd3 && b0[2:0] == 3'd4) ? 2 : 1;
        for (int i = k; i < 6; i++) b[i] = pat[(i - k) % 4];
        send(m32, b, n, 0);
    endtask

    task automatic random_op(input bit gap);
        logic [7:0] b [0:5];
        bit m32;
        int n;
        m32 = 1'($urandom);
        for (int i = 0; i < 6; i++) b[i] = 8'($urandom);
        n = need_len(b[0], b[1], 1, m32);
        send(m32, b, n, gap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13", "in_ready in reset", in_ready, 1);
        check("R13", "done in reset", done, 0);
        rst_n = 1'b1;
        running = 1'b1;
        // R2, R3, R4 in 16-bit mode
        directed(0, 8'hC3, 8'h00);
        directed(0, 8'h06, 8'h00);
        directed(0, 8'h46, 8'h00);
        directed(0, 8'h87, 8'h00);
        directed(0, 8'h00, 8'h00);
        directed(0, 8'h04, 8'h00);
        directed(0, 8'hBF, 8'h00);
        // R1: reg field varies, address form unchanged
        directed(0, 8'h7E, 8'h00);
        // R5, R7 in 32-bit mode
        directed(1, 8'h05, 8'h00);
        directed(1, 8'h83, 8'h00);
        directed(1, 8'h40, 8'h00);
        directed(1, 8'h3B, 8'h00);
        directed(1, 8'hFF, 8'h00);
        // R6, R8, R9 with SIB byte
        directed(1, 8'h04, 8'h25);
        directed(1, 8'h04, 8'hC8);
        directed(1, 8'h04, 8'h60);
        directed(1, 8'h44, 8'h9D);
        directed(1, 8'h84, 8'h65);
        directed(1, 8'h14, 8'hE5);
        // R11: stalls between bytes
        for (int i = 0; i < 300; i++) random_op(1);
        for (int i = 0; i < 300; i++) random_op(0);
        // R13: reset mid-operand
        begin
            logic [7:0] b [0:5];
            b[0] = 8'h84; b[1] = 8'h11; b[2] = 8'h22; b[3] = 8'h33; b[4] = 8'h44; b[5] = 8'h55;
            send(1, b, 3, 0);
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            check("R13", "in_ready after reset", in_ready, 1);
            check("R13", "done after reset", done, 0);
            directed(0, 8'h46, 8'h00);
        end
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule